// File: doc/BRIEF.md
# Descriptor Ring Ownership Manager

This block walks two circular rings of buffer descriptors kept in shared memory: a transmit ring and a receive ring. Each descriptor is four 16-bit words: buffer address, control/status, buffer length and a completion status word. The host hands a descriptor to the block by setting the ownership bit in its control/status word. The block finds such descriptors, passes each buffer's address and length to a data path, and gives the entry back to the host when the data path is done. Giving it back means writing completion status and clearing the ownership bit.

Scans start from a periodic poll tick, which covers both rings, or from a transmit-demand strobe, which covers the transmit ring only. A packet can span several chained descriptors. When a buffer without the end-of-packet flag finishes, the block looks ahead at the next entry. If the host does not own that entry, the block records a buffer error and an underflow in the finished descriptor. All descriptor traffic uses one word-wide request/grant memory port. Ring bases and sizes are configuration inputs.

Top module: `drm_ring_mgr`

## Requirements
- R1: After reset, mem_req and dp_valid are low and both ring indices are 0, so the first scan of each ring reads that ring's entry 0.
- R2: A poll_tick marks both rings for a scan and tx_demand marks only the transmit ring. A trigger that arrives while the block is busy is remembered, and triggers that coincide merge into one scan. When both rings are marked, the transmit ring is scanned first.
- R3: A scan reads word 1 of the current entry. Word address = ring base × 4 + index × 4 + word. Bit 15 of word 1 is the ownership bit (1 = owned by the block). If that bit is 0, the scan ends with no further access and the index is unchanged.
- R4: For an owned entry, the block reads word 0 (buffer address) and then word 2 (length). It then raises dp_valid with dp_addr, dp_len, dp_ring (0 = transmit, 1 = receive) and dp_last (bit 8 of word 1, end of packet). These outputs hold steady until dp_done, and there is no memory access while dp_valid is high.
- R5: To close an entry, the block writes word 3 and then word 1. The word 1 value is the word read at the start of the scan with bit 15 cleared.
- R6: After the word 1 write, the ring index advances by one. It wraps to 0 after entry 2^log2n − 1, where log2n runs from 0 to 7.
- R7: If dp_last is 0, after dp_done the block reads word 1 of the following entry (with wrap). If that entry is owned, the block closes the current entry with word 3 = 0x0000 and then scans the following entry without waiting for a trigger.
- R8: If that following entry is not owned, word 3 of the current entry is written as 0xC000 (bit 15 buffer error, bit 14 underflow). The entry is then closed and the block waits for a trigger.
- R9: A memory request keeps its address, write enable and write data unchanged until mem_gnt.
- R10: An entry whose end-of-packet flag is set is closed with word 3 = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_base | input | AW-2 | Transmit ring base, in units of 4 words |
| cfg_tx_log2n | input | 3 | Log2 of transmit ring entry count |
| cfg_rx_base | input | AW-2 | Receive ring base, in units of 4 words |
| cfg_rx_log2n | input | 3 | Log2 of receive ring entry count |
| poll_tick | input | 1 | Periodic scan trigger for both rings |
| tx_demand | input | 1 | Immediate transmit-ring scan trigger |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_gnt |
| dp_valid | output | 1 | Buffer handed to the data path |
| dp_ring | output | 1 | 0 transmit, 1 receive |
| dp_addr | output | 16 | Buffer address word |
| dp_len | output | 16 | Buffer length word |
| dp_last | output | 1 | Buffer ends a packet |
| dp_done | input | 1 | Data path finished the buffer |

## Verification
Two coincidences are provoked. In the first, a transmit-demand strobe lands in the same cycle as dp_done while a poll-started transmit buffer is completing. The bench then expects the transmit ring to be scanned again, ahead of the receive entry still pending from the poll. In the second, poll_tick and tx_demand arrive together on an idle block, and the bench expects exactly one status read per ring. A behavioural ring model in the bench predicts every granted access and every hand-off. The bench compares each one as it occurs, under varied grant stalls and data-path delays, and compares the descriptor memory image at the end of each scenario.

// File: rtl/drm_pkg.sv
`timescale 1ns/1ps
package drm_pkg;
   localparam int NRING   = 2;
   localparam int RING_TX = 0;
   localparam int RING_RX = 1;

   localparam logic [1:0] W_BUF  = 2'd0;
   localparam logic [1:0] W_CTL  = 2'd1;
   localparam logic [1:0] W_LEN  = 2'd2;
   localparam logic [1:0] W_DONE = 2'd3;

   localparam int OWN_BIT = 15;
   localparam int ENP_BIT = 8;
   localparam logic [15:0] OWN_MASK = 16'h8000;
   localparam logic [15:0] ERR_WORD = 16'hC000;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_CTL, ST_RD_BUF, ST_RD_LEN,
      ST_XFER, ST_PEEK, ST_WR_DONE, ST_WR_CTL
   } seq_t;
endpackage

// File: rtl/drm_ring_ptr.sv
`timescale 1ns/1ps
module drm_ring_ptr #(
   parameter int AW  = 24,
   parameter int IW  = 7,
   parameter int LNW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-3:0]   base,
   input  logic [LNW-1:0]  log2n,
   input  logic            advance,
   output logic [AW-3:0]   cur_ent,
   output logic [AW-3:0]   nxt_ent
);
   logic [IW-1:0] idx, nidx, mask;

   always_comb begin
      for (int i = 0; i < IW; i++)
         mask[i] = (i < int'(log2n));
   end

   assign nidx    = (idx + IW'(1)) & mask;
   assign cur_ent = base + {{(AW-2-IW){1'b0}}, idx};
   assign nxt_ent = base + {{(AW-2-IW){1'b0}}, nidx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (advance) idx <= nidx;
   end
endmodule

// File: rtl/drm_pend.sv
`timescale 1ns/1ps
module drm_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= set | (pend & ~clr);
   end
endmodule

// File: rtl/drm_ring_mgr.sv
`timescale 1ns/1ps
module drm_ring_mgr #(
   parameter int AW        = 24,
   parameter int MAX_LOG2N = 7,
   localparam int LNW      = $clog2(MAX_LOG2N + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-3:0]   cfg_tx_base,
   input  logic [LNW-1:0]  cfg_tx_log2n,
   input  logic [AW-3:0]   cfg_rx_base,
   input  logic [LNW-1:0]  cfg_rx_log2n,
   input  logic            poll_tick,
   input  logic            tx_demand,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [15:0]     mem_wdata,
   input  logic            mem_gnt,
   input  logic [15:0]     mem_rdata,
   output logic            dp_valid,
   output logic            dp_ring,
   output logic [15:0]     dp_addr,
   output logic [15:0]     dp_len,
   output logic            dp_last,
   input  logic            dp_done
);
   import drm_pkg::*;

   localparam int IW = MAX_LOG2N;

   if (MAX_LOG2N < 1 || MAX_LOG2N > 7) begin : g_bad_depth
      $error("MAX_LOG2N must lie in 1..7");
   end
   if (AW < IW + 3) begin : g_bad_aw
      $error("AW too narrow for the ring index");
   end

   seq_t          st;
   logic          cur;
   logic [15:0]   ctl_r, buf_r, len_r;
   logic          err_r, chain_r;

   logic [AW-3:0]  base_a [NRING];
   logic [LNW-1:0] ln_a   [NRING];
   logic [AW-3:0]  ent_a  [NRING];
   logic [AW-3:0]  nent_a [NRING];
   logic [NRING-1:0] pend_a, adv_a, clr_a, set_a;

   logic sel, take;
   assign take = |pend_a;
   assign sel  = pend_a[RING_TX] ? 1'b0 : 1'b1;

   assign base_a[RING_TX] = cfg_tx_base;
   assign base_a[RING_RX] = cfg_rx_base;
   assign ln_a[RING_TX]   = cfg_tx_log2n;
   assign ln_a[RING_RX]   = cfg_rx_log2n;

   for (genvar r = 0; r < NRING; r++) begin : g_ring
      if (r == RING_TX) begin : g_trig_tx
         assign set_a[r] = poll_tick | tx_demand;
      end else begin : g_trig_rx
         assign set_a[r] = poll_tick;
      end

      assign clr_a[r] = (st == ST_IDLE) && take && (sel == 1'(r));
      assign adv_a[r] = (st == ST_WR_CTL) && mem_gnt && (cur == 1'(r));

      drm_pend u_pend (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (set_a[r]),
         .clr  (clr_a[r]),
         .pend (pend_a[r])
      );

      drm_ring_ptr #(.AW(AW), .IW(IW), .LNW(LNW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .base   (base_a[r]),
         .log2n  (ln_a[r]),
         .advance(adv_a[r]),
         .cur_ent(ent_a[r]),
         .nxt_ent(nent_a[r])
      );
   end

   // address and request decode
   logic [AW-3:0] ebase;
   logic [1:0]    wsel;
   always_comb begin
      ebase     = ent_a[cur];
      wsel      = W_CTL;
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_wdata = '0;
      unique case (st)
         ST_RD_CTL:  wsel = W_CTL;
         ST_RD_BUF:  wsel = W_BUF;
         ST_RD_LEN:  wsel = W_LEN;
         ST_PEEK: begin
            ebase = nent_a[cur];
            wsel  = W_CTL;
         end
         ST_WR_DONE: begin
            wsel      = W_DONE;
            mem_we    = 1'b1;
            mem_wdata = err_r ? ERR_WORD : 16'h0000;
         end
         ST_WR_CTL: begin
            wsel      = W_CTL;
            mem_we    = 1'b1;
            mem_wdata = ctl_r & ~OWN_MASK;
         end
         default:    mem_req = 1'b0;
      endcase
   end
   assign mem_addr = {ebase, wsel};

   assign dp_valid = (st == ST_XFER);
   assign dp_ring  = cur;
   assign dp_addr  = buf_r;
   assign dp_len   = len_r;
   assign dp_last  = ctl_r[ENP_BIT];

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur     <= 1'b0;
         ctl_r   <= '0;
         buf_r   <= '0;
         len_r   <= '0;
         err_r   <= 1'b0;
         chain_r <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (take) begin
               cur <= sel;
               st  <= ST_RD_CTL;
            end
            ST_RD_CTL: if (mem_gnt) begin
               ctl_r <= mem_rdata;
               st    <= mem_rdata[OWN_BIT] ? ST_RD_BUF : ST_IDLE;
            end
            ST_RD_BUF: if (mem_gnt) begin
               buf_r <= mem_rdata;
               st    <= ST_RD_LEN;
            end
            ST_RD_LEN: if (mem_gnt) begin
               len_r <= mem_rdata;
               st    <= ST_XFER;
            end
            ST_XFER: if (dp_done) begin
               if (ctl_r[ENP_BIT]) begin
                  err_r   <= 1'b0;
                  chain_r <= 1'b0;
                  st      <= ST_WR_DONE;
               end else begin
                  st      <= ST_PEEK;
               end
            end
            ST_PEEK: if (mem_gnt) begin
               err_r   <= ~mem_rdata[OWN_BIT];
               chain_r <=  mem_rdata[OWN_BIT];
               st      <= ST_WR_DONE;
            end
            ST_WR_DONE: if (mem_gnt) st <= ST_WR_CTL;
            ST_WR_CTL:  if (mem_gnt) st <= chain_r ? ST_RD_CTL : ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/drm_ring_mgr_chk.sv
`timescale 1ns/1ps
module drm_ring_mgr_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [15:0]   mem_wdata,
   input logic          mem_gnt,
   input logic          dp_valid,
   input logic          dp_done,
   input logic          dp_ring,
   input logic [15:0]   dp_addr,
   input logic [15:0]   dp_len,
   input logic          dp_last
);
   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r4_handoff_held: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid && !dp_done |=> dp_valid && $stable(dp_addr) && $stable(dp_len)
                               && $stable(dp_ring) && $stable(dp_last));

   a_r4_no_mem_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid |-> !mem_req);

   a_r4_len_before_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dp_valid) |-> $past(mem_req && mem_gnt && !mem_we && mem_addr[1:0] == 2'd2));

   a_r5_own_released: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_addr[1:0] == 2'd1 |-> !mem_wdata[15]);

   a_r5_done_word_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req && mem_we && mem_addr[1:0] == 2'd1)
         |-> $past(mem_req && mem_we && mem_gnt && mem_addr[1:0] == 2'd3));

   a_r8_done_word_value: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_addr[1:0] == 2'd3 |-> mem_wdata == 16'h0000 || mem_wdata == 16'hC000);
endmodule

bind drm_ring_mgr drm_ring_mgr_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_gnt  (mem_gnt),
   .dp_valid (dp_valid),
   .dp_done  (dp_done),
   .dp_ring  (dp_ring),
   .dp_addr  (dp_addr),
   .dp_len   (dp_len),
   .dp_last  (dp_last)
);

// File: tb/sim_drm_ring_mgr.sv
`timescale 1ns/1ps
module sim_drm_ring_mgr;
   localparam int AW  = 24;
   localparam int TXW = 'h100;
   localparam int RXW = 'h200;
   localparam int TXL = 2;
   localparam int RXL = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic poll_tick = 1'b0, tb_demand = 1'b0, resp_demand = 1'b0, tx_demand;
   logic mem_req, mem_we, mem_gnt = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata = '0;
   logic dp_valid, dp_ring, dp_last, dp_done = 1'b0;
   logic [15:0] dp_addr, dp_len;
   assign tx_demand = tb_demand | resp_demand;

   drm_ring_mgr #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_tx_base(22'(TXW / 4)), .cfg_tx_log2n(3'(TXL)),
      .cfg_rx_base(22'(RXW / 4)), .cfg_rx_log2n(3'(RXL)),
      .poll_tick(poll_tick), .tx_demand(tx_demand),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .dp_valid(dp_valid), .dp_ring(dp_ring), .dp_addr(dp_addr), .dp_len(dp_len),
      .dp_last(dp_last), .dp_done(dp_done)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [15:0] mem     [0:1023];
   logic [15:0] ref_mem [0:1023];
   int ridx [2];
   bit eq_we[$];
   int eq_addr[$];
   int eq_data[$];
   int ed_ring[$], ed_addr[$], ed_len[$], ed_last[$];
   bit demand_on_done = 1'b0;
   int stall = 0, dpwait = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic push(input bit we, input int a, input int d);
      eq_we.push_back(we); eq_addr.push_back(a); eq_data.push_back(d);
   endtask

   // behavioural ring model: predicts every access and hand-off of one scan
   task automatic serve(input int r);
      int base, n, i, e, nx, ne;
      bit go, own;
      base = (r == 0) ? TXW : RXW;
      n    = (r == 0) ? (1 << TXL) : (1 << RXL);
      go   = 1'b1;
      while (go) begin
         i = ridx[r];
         e = base + 4 * i;
         push(0, e + 1, 0);
         if (!ref_mem[e+1][15]) go = 1'b0;
         else begin
            push(0, e, 0);
            push(0, e + 2, 0);
            ed_ring.push_back(r); ed_addr.push_back(int'(ref_mem[e]));
            ed_len.push_back(int'(ref_mem[e+2])); ed_last.push_back(int'(ref_mem[e+1][8]));
            nx = (i + 1) % n;
            ne = base + 4 * nx;
            if (ref_mem[e+1][8]) begin
               push(1, e + 3, 0); ref_mem[e+3] = 16'h0000; go = 1'b0;
            end else begin
               push(0, ne + 1, 0);
               own = ref_mem[ne+1][15];
               push(1, e + 3, own ? 0 : 'hC000);
               ref_mem[e+3] = own ? 16'h0000 : 16'hC000;
               go = own;
            end
            push(1, e + 1, int'(ref_mem[e+1] & 16'h7FFF));
            ref_mem[e+1] = ref_mem[e+1] & 16'h7FFF;
            ridx[r] = nx;
         end
      end
   endtask

   task automatic setd(input int e, input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
      mem[e] = w0; mem[e+1] = w1; mem[e+2] = w2; mem[e+3] = 16'h5A5A;
      ref_mem[e] = w0; ref_mem[e+1] = w1; ref_mem[e+2] = w2; ref_mem[e+3] = 16'h5A5A;
   endtask

   function automatic string tag_of(input bit we, input int a, input int d);
      if (!we) return ((a % 4) == 1) ? "R3" : "R4";
      if ((a % 4) == 1) return "R5";
      return (d != 0) ? "R8" : "R10";
   endfunction

   // memory responder with stalls; checks every granted access against the model
   always @(negedge clk) begin
      mem_gnt = 1'b0;
      if (rst_n && mem_req) begin
         if (stall > 0) stall--;
         else begin
            if (eq_addr.size() == 0)
               chk(1'b0, "R2", "unexpected access", int'(mem_addr), 0);
            else begin
               bit we; int a, d; string t;
               we = eq_we.pop_front(); a = eq_addr.pop_front(); d = eq_data.pop_front();
               t = tag_of(we, a, d);
               chk(mem_we == we, t, "access kind", int'(mem_we), int'(we));
               chk(int'(mem_addr) == a, t, "access address", int'(mem_addr), a);
               if (we) chk(int'(mem_wdata) == d, t, "write data", int'(mem_wdata), d);
            end
            if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
            mem_rdata = mem[mem_addr[9:0]];
            mem_gnt = 1'b1;
            stall = cyc % 3;
         end
      end
   end

   // data-path responder
   always @(negedge clk) begin
      if (dp_done) begin
         dp_done = 1'b0;
         resp_demand = 1'b0;
      end else if (rst_n && dp_valid) begin
         if (dpwait > 0) dpwait--;
         else begin
            if (ed_addr.size() == 0) chk(1'b0, "R4", "unexpected hand-off", int'(dp_addr), 0);
            else begin
               int r, a, l, z;
               r = ed_ring.pop_front(); a = ed_addr.pop_front(); l = ed_len.pop_front(); z = ed_last.pop_front();
               chk(int'(dp_ring) == r, "R4", "dp_ring", int'(dp_ring), r);
               chk(int'(dp_addr) == a, "R4", "dp_addr", int'(dp_addr), a);
               chk(int'(dp_len) == l, "R4", "dp_len", int'(dp_len), l);
               chk(int'(dp_last) == z, "R4", "dp_last", int'(dp_last), z);
            end
            dp_done = 1'b1;
            if (demand_on_done) begin
               resp_demand = 1'b1;
               demand_on_done = 1'b0;
            end
            dpwait = cyc % 4;
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
         summary();
      end
   end

   task automatic pulse_poll();
      @(negedge clk); poll_tick = 1'b1;
      @(negedge clk); poll_tick = 1'b0;
   endtask

   task automatic pulse_demand();
      @(negedge clk); tb_demand = 1'b1;
      @(negedge clk); tb_demand = 1'b0;
   endtask

   task automatic settle(input string req);
      int t;
      t = 0;
      while ((eq_addr.size() != 0 || ed_addr.size() != 0) && t < 3000) begin
         @(negedge clk); t++;
      end
      repeat (12) @(negedge clk);
      chk(eq_addr.size() == 0 && ed_addr.size() == 0, req, "predicted traffic left",
          eq_addr.size() + ed_addr.size(), 0);
      for (int a = TXW; a < TXW + 4 * (1 << TXL); a++)
         chk(mem[a] == ref_mem[a], "R5", "tx ring image", int'(mem[a]), int'(ref_mem[a]));
      for (int a = RXW; a < RXW + 4 * (1 << RXL); a++)
         chk(mem[a] == ref_mem[a], "R5", "rx ring image", int'(mem[a]), int'(ref_mem[a]));
   endtask

   initial begin
      for (int a = 0; a < 1024; a++) begin
         mem[a] = '0; ref_mem[a] = '0;
      end
      ridx[0] = 0; ridx[1] = 0;
      repeat (3) @(negedge clk);
      chk(mem_req == 1'b0 && dp_valid == 1'b0, "R1", "outputs in reset", int'({mem_req, dp_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req == 1'b0 && dp_valid == 1'b0, "R1", "idle after reset", int'({mem_req, dp_valid}), 0);

      // nothing owned: one status read per ring, tx first, from entry 0 (R1, R2, R3)
      serve(0); serve(1);
      pulse_poll();
      settle("R2");

      // single-buffer packet on tx (R4, R5, R10); other word-1 bits preserved
      setd(TXW + 0, 16'h1234, 16'h8155, 16'h0040);
      serve(0);
      pulse_demand();
      settle("R10");

      // chained packet across tx entries 1 and 2 (R7)
      setd(TXW + 4, 16'h2000, 16'h8000, 16'h0100);
      setd(TXW + 8, 16'h2100, 16'h8100, 16'h0022);
      serve(0);
      pulse_demand();
      settle("R7");

      // chain into a host-owned entry across the wrap (R8, R6)
      setd(TXW + 12, 16'h3000, 16'h8000, 16'h0010);
      serve(0);
      pulse_demand();
      settle("R8");

      // rx ring wraps after two entries (R6)
      setd(RXW + 0, 16'h4000, 16'h8100, 16'h0600);
      setd(RXW + 4, 16'h4100, 16'h8100, 16'h0601);
      serve(0); serve(1);
      pulse_poll();
      settle("R6");
      serve(0); serve(1);
      pulse_poll();
      settle("R6");
      setd(RXW + 0, 16'h4200, 16'h8100, 16'h0602);
      serve(0); serve(1);
      pulse_poll();
      settle("R6");

      // demand coincides with dp_done: tx rescanned before pending rx (R2)
      setd(TXW + 0, 16'h5000, 16'h8100, 16'h0077);
      setd(RXW + 4, 16'h5100, 16'h8100, 16'h0078);
      serve(0); serve(0); serve(1);
      demand_on_done = 1'b1;
      pulse_poll();
      settle("R2");

      // poll and demand in the same cycle merge into one tx scan (R2)
      serve(0); serve(1);
      @(negedge clk); poll_tick = 1'b1; tb_demand = 1'b1;
      @(negedge clk); poll_tick = 1'b0; tb_demand = 1'b0;
      settle("R2");

      summary();
   end
endmodule